// File: doc/BRIEF.md
# Six-Pin Bidirectional Port with Bit Read-Modify-Write

This block is the general-purpose pin port of a small microcontroller-style core. It keeps one output data latch bit and one direction bit per pin. It drives the pad output levels and output enables, and it samples the pad input levels. The core talks to it through a command strobe. The commands are: whole-port write, whole-port read, direction load, and single-bit set or clear.

Every command follows a four-phase instruction cycle, Q1 to Q4. The port samples its pins at the end of Q1, and the results of a command land at the end of Q4. A bit set or bit clear does not work on the latch. It reads back the sampled pin levels, forces one bit, and writes the whole word into the latch. As a result, any pin that is an input at that moment has its latch bit replaced by the level outside the chip. That replaced value appears on the pin once the pin is turned into an output.

Because pins are sampled early and writes land late, a read placed right after a write sees the old pin level when the pad settles slowly. One spare cycle between the two is enough to see the new level.

Top module: `gpio_rmw_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the port resets. All direction bits become 1, so `pad_oe` is 000000. `pad_out` is 000000, `rd_data` is 000000, and `q_phase` is 0 (Q1).
- R2: `q_phase` advances by one on each clock: 0, 1, 2, 3, then back to 0. The values 0 to 3 stand for Q1 to Q4.
- R3: A command is taken only when `cmd_valid` is high on the clock whose `q_phase` is 0. A strobe given in any other phase has no effect.
- R4: Write (`cmd_op` = 1) loads `cmd_wdata` into the output latch at the clock edge that ends Q4 of the same instruction cycle. `pad_out`, `pad_oe` and `rd_data` change at no other edge.
- R5: Direction load (`cmd_op` = 5) loads `cmd_wdata` into the direction bits at the end of Q4. A bit of 1 makes the pin an input and a bit of 0 makes it an output, so `pad_oe` is the bitwise inverse of the direction bits.
- R6: Read (`cmd_op` = 2) returns the `pad_in` value sampled at the end of Q1. This value appears on `rd_data` at the end of Q4 and stays there until the next read.
- R7: Bit set (`cmd_op` = 3) and bit clear (`cmd_op` = 4) write into the whole latch the `pad_in` value sampled at the end of Q1, with bit `cmd_idx` forced to 1 or 0. For an input pin, the latch therefore takes the level outside the chip.
- R8: A latch bit replaced while its pin was an input is the level driven on `pad_out` once a direction load makes that pin an output.
- R9: A bit set or clear with `cmd_idx` 6 or 7 forces no bit. It still writes the sampled pin levels into the latch.
- R10: Operation codes 0, 6 and 7 change neither the latch, the direction bits nor `rd_data`.
- R11: If a read directly follows a write and the pad needs more than one clock to settle, the read returns the pin level from before the write. If one non-port cycle lies between them, the read returns the new level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; four clocks form one instruction cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, taken in Q1 |
| cmd_op | input | 3 | Operation: 1 write, 2 read, 3 set bit, 4 clear bit, 5 direction load |
| cmd_idx | input | 3 | Bit index for set and clear |
| cmd_wdata | input | 6 | Data for write and direction load |
| rd_data | output | 6 | Pin levels returned by the last read |
| pad_in | input | 6 | Pin levels seen at the pads |
| pad_out | output | 6 | Output data latch driven to the pads |
| pad_oe | output | 6 | Output enable per pin, 1 drives the pin |
| q_phase | output | 2 | Current phase, 0 to 3 for Q1 to Q4 |

## Verification
Two port functions meet when one instruction cycle ends with a write landing in Q4 and the next cycle opens with a read sampling the pins in Q1. The bench provokes this by sending a write and a read back to back while the pad model has a settling delay of one clock. It expects the old level in this case, and the new level once a spare cycle separates the two commands. The bit clear on a partly-input port meets a second pair of functions: the write-back of the bit clear overwrites latch bits that belong to input pins. The bench judges this by turning those pins into outputs and reading the levels they then drive.

// File: rtl/gpio_rmw_pkg.sv
// Shared definitions for the bit-operation pin port.
// Assumes: operation codes are three bits wide; codes 6 and 7 are reserved.
package gpio_rmw_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_WRITE = 3'd1,
        OP_READ  = 3'd2,
        OP_SET   = 3'd3,
        OP_CLR   = 3'd4,
        OP_DIR   = 3'd5
    } port_op_e;

    localparam int unsigned OP_LAST_LEGAL = 5;

endpackage

// File: rtl/gpio_phase_seq.sv
// Free-running instruction-cycle phase counter.
// Assumes: PHASES >= 2; phase 0 is the first phase and PHASES-1 the last.
module gpio_phase_seq #(
    parameter int PHASES = 4,
    parameter int PW     = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase,
    output logic          first,
    output logic          last
);

    localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);

    // Advance one phase per clock, wrapping after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (phase == LAST_PH)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign first = (phase == '0);
    assign last  = (phase == LAST_PH);

endmodule

// File: rtl/gpio_cmd_capture.sv
// Captures a command and the pad levels at the end of the first phase, and
// holds them until the cycle's last phase has executed them.
// Assumes: the command strobe lasts one clock and is only honoured in phase 0.
module gpio_cmd_capture
    import gpio_rmw_pkg::*;
#(
    parameter int NPINS = 6,
    parameter int IDXW  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first,
    input  logic             last,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [IDXW-1:0]  cmd_idx,
    input  logic [NPINS-1:0] cmd_wdata,
    input  logic [NPINS-1:0] pad_in,
    output port_op_e         pend_op,
    output logic [IDXW-1:0]  pend_idx,
    output logic [NPINS-1:0] pend_data,
    output logic [NPINS-1:0] pin_sample
);

    logic op_legal;
    assign op_legal = (int'(cmd_op) <= OP_LAST_LEGAL);

    // Sample the pad levels once per instruction cycle, at the end of phase 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_sample <= '0;
        else if (first)
            pin_sample <= pad_in;
    end

    // Hold the accepted command until its execution in the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_op   <= OP_NONE;
            pend_idx  <= '0;
            pend_data <= '0;
        end else if (first) begin
            pend_op   <= (cmd_valid && op_legal) ? port_op_e'(cmd_op) : OP_NONE;
            pend_idx  <= cmd_idx;
            pend_data <= cmd_wdata;
        end else if (last) begin
            pend_op   <= OP_NONE;
        end
    end

endmodule

// File: rtl/gpio_port_regs.sv
// Output latch, direction bits and read register; executes the pending
// command at the end of the last phase. Bit operations work on the
// sampled pad levels, not on the latch.
// Assumes: an index at or above NPINS selects no bit.
module gpio_port_regs
    import gpio_rmw_pkg::*;
#(
    parameter int NPINS = 6,
    parameter int IDXW  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             last,
    input  port_op_e         pend_op,
    input  logic [IDXW-1:0]  pend_idx,
    input  logic [NPINS-1:0] pend_data,
    input  logic [NPINS-1:0] pin_sample,
    output logic [NPINS-1:0] out_latch,
    output logic [NPINS-1:0] dir_bits,
    output logic [NPINS-1:0] rd_reg
);

    logic [NPINS-1:0] bit_mask;

    // One-hot mask of the addressed bit; all zero for an index out of range.
    for (genvar g = 0; g < NPINS; g++) begin : g_mask
        assign bit_mask[g] = (pend_idx == IDXW'(g));
    end

    // Apply the pending command at the end of the instruction cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_latch <= '0;
            dir_bits  <= '1;
            rd_reg    <= '0;
        end else if (last) begin
            unique case (pend_op)
                OP_WRITE: out_latch <= pend_data;
                OP_SET:   out_latch <= pin_sample | bit_mask;
                OP_CLR:   out_latch <= pin_sample & ~bit_mask;
                OP_DIR:   dir_bits  <= pend_data;
                OP_READ:  rd_reg    <= pin_sample;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_rmw_port.sv
// Top of the six-pin bidirectional port. It ties together the phase counter,
// the command and pad capture, and the register bank.
// Assumes: pads are external; a direction bit of 1 means input.
module gpio_rmw_port
    import gpio_rmw_pkg::*;
#(
    parameter int NPINS  = 6,
    parameter int IDXW   = $clog2(NPINS),
    parameter int PHASES = 4,
    parameter int PW     = $clog2(PHASES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [IDXW-1:0]  cmd_idx,
    input  logic [NPINS-1:0] cmd_wdata,
    output logic [NPINS-1:0] rd_data,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [PW-1:0]    q_phase
);

    logic             ph_first;
    logic             ph_last;
    port_op_e         pend_op;
    logic [IDXW-1:0]  pend_idx;
    logic [NPINS-1:0] pend_data;
    logic [NPINS-1:0] pin_sample;
    logic [NPINS-1:0] dir_bits;

    gpio_phase_seq #(.PHASES(PHASES), .PW(PW)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (q_phase),
        .first (ph_first),
        .last  (ph_last)
    );

    gpio_cmd_capture #(.NPINS(NPINS), .IDXW(IDXW)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .first      (ph_first),
        .last       (ph_last),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_idx    (cmd_idx),
        .cmd_wdata  (cmd_wdata),
        .pad_in     (pad_in),
        .pend_op    (pend_op),
        .pend_idx   (pend_idx),
        .pend_data  (pend_data),
        .pin_sample (pin_sample)
    );

    gpio_port_regs #(.NPINS(NPINS), .IDXW(IDXW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .last       (ph_last),
        .pend_op    (pend_op),
        .pend_idx   (pend_idx),
        .pend_data  (pend_data),
        .pin_sample (pin_sample),
        .out_latch  (pad_out),
        .dir_bits   (dir_bits),
        .rd_reg     (rd_data)
    );

    // Drive a pin whose direction bit says output.
    assign pad_oe = ~dir_bits;

endmodule

// File: rtl/gpio_rmw_port_chk.sv
// Property checker for the bit-operation port, bound into the top module.
// Assumes: it sees the pending command registers through the bind.
module gpio_rmw_port_chk
    import gpio_rmw_pkg::*;
#(
    parameter int NPINS  = 6,
    parameter int IDXW   = 3,
    parameter int PHASES = 4,
    parameter int PW     = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] rd_data,
    input logic [PW-1:0]    q_phase,
    input port_op_e         pend_op,
    input logic [IDXW-1:0]  pend_idx
);

    localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pad_oe == '0 && pad_out == '0 && rd_data == '0 && q_phase == '0));

    p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> q_phase == (($past(q_phase) == LAST_PH) ? '0 : $past(q_phase) + 1'b1));

    p_late_cmd_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && q_phase != '0 && q_phase != LAST_PH) |=> pend_op == $past(pend_op));

    p_update_at_q4_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && q_phase != '0) |-> ($stable(pad_out) && $stable(pad_oe) && $stable(rd_data)));

    p_set_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_phase == LAST_PH && pend_op == OP_SET && pend_idx < IDXW'(NPINS)) |=> pad_out[$past(pend_idx)]);

    p_clr_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_phase == LAST_PH && pend_op == OP_CLR && pend_idx < IDXW'(NPINS)) |=> !pad_out[$past(pend_idx)]);

endmodule

bind gpio_rmw_port gpio_rmw_port_chk #(
    .NPINS(NPINS), .IDXW(IDXW), .PHASES(PHASES), .PW(PW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .rd_data   (rd_data),
    .q_phase   (q_phase),
    .pend_op   (pend_op),
    .pend_idx  (pend_idx)
);

// File: tb/gpio_rmw_port_bench.sv
// Bench: pad model with a variable settling delay, a behavioural cycle model
// compared on every clock, and directed checks per requirement.
module gpio_rmw_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [2:0] cmd_idx = 3'd0;
    logic [5:0] cmd_wdata = 6'd0;
    logic [5:0] rd_data;
    logic [5:0] pad_in = 6'd0;
    logic [5:0] pad_out;
    logic [5:0] pad_oe;
    logic [1:0] q_phase;

    int n_cmp = 0;
    int n_bad = 0;
    int settle = 0;
    logic [5:0] ext_lvl = 6'd0;
    logic [5:0] hist [0:7];

    always #2 clk = ~clk;

    gpio_rmw_port u_gpio_rmw_port (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .q_phase(q_phase)
    );

    task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Pad model: the line level reaches pad_in after `settle` negedges.
    always @(negedge clk) begin
        logic [5:0] lvl;
        for (int b = 0; b < 6; b++) lvl[b] = pad_oe[b] ? pad_out[b] : ext_lvl[b];
        for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = lvl;
        pad_in <= hist[settle];
    end

    // Behavioural reference of the port, stepped on each rising edge.
    int m_ph = 0;
    logic [5:0] m_lat = 6'd0, m_dir = 6'h3f, m_rd = 6'd0, m_smp = 6'd0, m_dat = 6'd0;
    int m_op = 0, m_idx = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_lat = 6'd0; m_dir = 6'h3f; m_rd = 6'd0; m_op = 0;
        end else begin
            if (m_ph == 0) begin
                m_smp = pad_in;
                m_op  = (cmd_valid && cmd_op <= 3'd5) ? int'(cmd_op) : 0;
                m_idx = int'(cmd_idx);
                m_dat = cmd_wdata;
            end
            if (m_ph == 3) begin
                case (m_op)
                    1: m_lat = m_dat;
                    2: m_rd  = m_smp;
                    3: begin m_lat = m_smp; if (m_idx < 6) m_lat[m_idx] = 1'b1; end
                    4: begin m_lat = m_smp; if (m_idx < 6) m_lat[m_idx] = 1'b0; end
                    5: m_dir = m_dat;
                    default: ;
                endcase
                m_op = 0;
            end
            m_ph = (m_ph + 1) % 4;
        end
    end

    // Every-clock comparison against the reference model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 phase", {4'd0, q_phase}, 6'(m_ph));
            chk("R4 pad_out", pad_out, m_lat);
            chk("R5 pad_oe", pad_oe, ~m_dir);
            chk("R6 rd_data", rd_data, m_rd);
        end
    end

    // Issue one command in the next Q1 and wait until its results are visible.
    task automatic issue(input logic [2:0] op, input logic [2:0] idx, input logic [5:0] d);
        while (q_phase != 2'd0) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) hist[k] = 6'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state just after reset
        chk("R1 pad_oe", pad_oe, 6'b000000);
        chk("R1 pad_out", pad_out, 6'b000000);
        chk("R1 rd_data", rd_data, 6'b000000);
        chk("R1 q_phase", {4'd0, q_phase}, 6'd0);
        // R2: phase sequence over two instruction cycles
        for (int c = 0; c < 8; c++) begin
            chk("R2 sequence", {4'd0, q_phase}, 6'(c % 4));
            @(negedge clk);
        end
        // R5: upper three pins inputs, lower three outputs
        issue(3'd5, 3'd0, 6'b111000);
        chk("R5 dir load", pad_oe, 6'b000111);
        // R4: whole-port write
        issue(3'd1, 3'd0, 6'b011000);
        chk("R4 write", pad_out, 6'b011000);
        ext_lvl = 6'b100000;
        issue(3'd0, 3'd0, 6'd0);
        // R7: clear bit 4 copies outside levels into input latches
        issue(3'd4, 3'd4, 6'd0);
        chk("R7 clr overwrite", pad_out, 6'b100000);
        // R8: overwritten bit 5 now driven
        issue(3'd5, 3'd0, 6'b000000);
        chk("R8 oe", pad_oe, 6'b111111);
        chk("R8 driven", pad_out, 6'b100000);
        // R7: set bit 1 on all-output port
        issue(3'd3, 3'd1, 6'd0);
        chk("R7 set", pad_out, 6'b100010);
        // R9: index 7 forces nothing
        issue(3'd3, 3'd7, 6'd0);
        chk("R9 idx7", pad_out, 6'b100010);
        // R9: index 6 on an all-input port writes back the pin levels
        issue(3'd5, 3'd0, 6'b111111);
        ext_lvl = 6'b010101;
        issue(3'd0, 3'd0, 6'd0);
        issue(3'd4, 3'd6, 6'd0);
        chk("R9 idx6 writeback", pad_out, 6'b010101);
        // R10: reserved codes change nothing
        issue(3'd6, 3'd0, 6'b111111);
        issue(3'd7, 3'd2, 6'b111111);
        issue(3'd0, 3'd0, 6'b111111);
        chk("R10 latch", pad_out, 6'b010101);
        chk("R10 dir", pad_oe, 6'b000000);
        chk("R10 rd", rd_data, 6'b000000);
        // R3: strobe in Q2 ignored
        while (q_phase != 2'd0) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_wdata = 6'b000000;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        while (q_phase != 2'd0) @(negedge clk);
        chk("R3 late strobe", pad_out, 6'b010101);
        // R6: read of input levels
        issue(3'd2, 3'd0, 6'd0);
        chk("R6 read inputs", rd_data, 6'b010101);
        // R6: read of driven levels, fast pads
        issue(3'd5, 3'd0, 6'b000000);
        issue(3'd1, 3'd0, 6'b001100);
        issue(3'd0, 3'd0, 6'd0);
        issue(3'd2, 3'd0, 6'd0);
        chk("R6 read outputs", rd_data, 6'b001100);
        // R11: slow pads, write then read back to back
        settle = 1;
        issue(3'd1, 3'd0, 6'b110011);
        chk("R6 rd held", rd_data, 6'b001100);
        issue(3'd2, 3'd0, 6'd0);
        chk("R11 stale read", rd_data, 6'b001100);
        issue(3'd0, 3'd0, 6'd0);
        issue(3'd2, 3'd0, 6'd0);
        chk("R11 spaced read", rd_data, 6'b110011);
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule